// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block is the register-write front end of a programmable interrupt controller that always runs as one of a cascaded pair. Software writes bytes to two offsets: an even command port and an odd data port. A command-port byte with bit 4 set opens the initialization sequence and forces a defined starting state. The next three data-port bytes then fill, in order, the vector base, the cascade identity and the mode flags. Once that sequence is closed, data-port bytes go straight into the interrupt mask. Command-port bytes with bit 4 clear are operation commands. They adjust the lowest-priority line, the special-mask flag and the status read selection.

The block only holds configuration. A priority resolver, the acknowledge logic and the trigger-mode logic sit elsewhere and read its outputs. The `init_busy` output tells those neighbours that the configuration is still being built.

Top module: `pic_init_seq`

## Requirements
- R1: After synchronous reset, every configuration output reads as follows: `irq_mask` is 0, `lowest_prio` is 7, `cascade_id` is 7, `vec_base` is 0, `mode_flags` is 0, `spec_mask` is 0, `read_isr` is 0, `init_busy` is 0 and `icw1_illegal` is 0.
- R2: A write with `port_sel`=0 and `wr_data[4]`=1 is the start word. In the following cycle `init_busy` reads 1.
- R3: The start word clears `irq_mask` to 0. It sets `lowest_prio` to 7 and `cascade_id` to 7. It clears `spec_mask`, and it clears `read_isr` so that the request register is selected.
- R4: After a start word, the first three writes with `port_sel`=1 load, in order, `vec_base` from `wr_data[7:3]`, `cascade_id` from `wr_data[7:0]` and `mode_flags` from `wr_data[4:0]`. `init_busy` falls in the cycle after the third of these writes, and `irq_mask` does not change while the three words are being taken.
- R5: Bits 3 and 2 of the start word affect no output.
- R6: `icw1_illegal` is loaded on each start word. It reads 1 when bit 0 of that word is 0 or bit 1 of that word is 1, and 0 otherwise. An illegal start word still expects three data words.
- R7: A start word written before the sequence has finished restarts it. The next data write is taken as the vector-base word.
- R8: While `init_busy` is 0, a data-port write loads `irq_mask` from `wr_data`.
- R9: A command write with bit 4=0 and bit 3=1 selects the read and mask word. If bit 6 is 1, `spec_mask` takes bit 5. If bit 1 is 1, `read_isr` takes bit 0. When an enable bit is 0, the corresponding output is left unchanged.
- R10: A command write with bit 4=0 and bit 3=0 selects the priority word. If bits 7:6 are 11, `lowest_prio` takes bits 2:0. Any other code leaves `lowest_prio` unchanged.
- R11: Operation command words take effect even while `init_busy` is 1. They do not count as sequence words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| port_sel | input | 1 | 0 selects the command port, 1 selects the data port |
| wr_data | input | 8 | Write data |
| vec_base | output | 5 | Interrupt vector base |
| cascade_id | output | 8 | Cascade identity / slave address |
| mode_flags | output | 5 | Mode bits from the fourth word |
| irq_mask | output | 8 | Interrupt mask |
| lowest_prio | output | 3 | Line that holds the lowest priority |
| spec_mask | output | 1 | Special mask mode |
| read_isr | output | 1 | 1 selects the in-service register for status reads, 0 the request register |
| init_busy | output | 1 | Initialization sequence in progress |
| icw1_illegal | output | 1 | Last start word had an illegal bit value |

## Verification
The hardest case to reach is a start word arriving partway through the sequence, especially when operation words are interleaved. Both change which data byte lands where, and from the ports alone that is seen only through the later fields. The stimulus restarts after one data word, mixes operation words between the sequence words, and ends with a long pseudo-random stream of mixed writes. A behavioural reference model in the bench tracks the step count and is compared against every output each cycle.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;

    localparam int BYTE_W = 8;
    localparam int START_BIT = 4;
    localparam int OCW_SEL_BIT = 3;

    typedef enum logic [1:0] {
        STEP_IDLE,
        STEP_VEC,
        STEP_CASC,
        STEP_MODE
    } step_e;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_START,
        WR_PRIO,
        WR_RDMASK,
        WR_DATA
    } wr_kind_e;

    function automatic wr_kind_e classify(input logic we, input logic port,
                                          input logic [BYTE_W-1:0] d);
        if (!we)
            return WR_NONE;
        if (port)
            return WR_DATA;
        if (d[START_BIT])
            return WR_START;
        if (d[OCW_SEL_BIT])
            return WR_RDMASK;
        return WR_PRIO;
    endfunction

    function automatic logic start_word_bad(input logic [BYTE_W-1:0] d);
        return (!d[0]) || d[1];
    endfunction

    function automatic step_e step_after(input step_e s);
        case (s)
            STEP_VEC:  return STEP_CASC;
            STEP_CASC: return STEP_MODE;
            default:   return STEP_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
    import pic_init_pkg::*;
(
    input  logic              wr_en,
    input  logic              port_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output wr_kind_e          kind
);
    always_comb kind = classify(wr_en, port_sel, wr_data);
endmodule

// File: rtl/pic_init_step.sv
module pic_init_step
    import pic_init_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_kind_e kind,
    output step_e    step,
    output logic     busy
);
    always_ff @(posedge clk) begin
        if (rst)
            step <= STEP_IDLE;
        else if (kind == WR_START)
            step <= STEP_VEC;
        else if (kind == WR_DATA && step != STEP_IDLE)
            step <= step_after(step);
    end

    always_comb busy = (step != STEP_IDLE);
endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
    import pic_init_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int MODE_W = 5,
    localparam int PRIO_W = $clog2(NUM_LINES),
    localparam int VEC_W = BYTE_W - PRIO_W
)(
    input  logic              clk,
    input  logic              rst,
    input  wr_kind_e          kind,
    input  step_e             step,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [VEC_W-1:0]  vec_base,
    output logic [BYTE_W-1:0] cascade_id,
    output logic [MODE_W-1:0] mode_flags,
    output logic [NUM_LINES-1:0] irq_mask,
    output logic [PRIO_W-1:0] lowest_prio,
    output logic              spec_mask,
    output logic              read_isr,
    output logic              icw1_illegal
);
    localparam logic [PRIO_W-1:0] PRIO_DFLT = PRIO_W'(NUM_LINES - 1);
    localparam logic [BYTE_W-1:0] SLAVE_DFLT = BYTE_W'(7);

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_base     <= '0;
            cascade_id   <= SLAVE_DFLT;
            mode_flags   <= '0;
            irq_mask     <= '0;
            lowest_prio  <= PRIO_DFLT;
            spec_mask    <= 1'b0;
            read_isr     <= 1'b0;
            icw1_illegal <= 1'b0;
        end else begin
            case (kind)
                WR_START: begin
                    irq_mask     <= '0;
                    lowest_prio  <= PRIO_DFLT;
                    cascade_id   <= SLAVE_DFLT;
                    spec_mask    <= 1'b0;
                    read_isr     <= 1'b0;
                    icw1_illegal <= start_word_bad(wr_data);
                end
                WR_DATA: begin
                    case (step)
                        STEP_VEC:  vec_base   <= wr_data[BYTE_W-1:PRIO_W];
                        STEP_CASC: cascade_id <= wr_data;
                        STEP_MODE: mode_flags <= wr_data[MODE_W-1:0];
                        default:   irq_mask   <= wr_data[NUM_LINES-1:0];
                    endcase
                end
                WR_PRIO: begin
                    if (wr_data[7:6] == 2'b11)
                        lowest_prio <= wr_data[PRIO_W-1:0];
                end
                WR_RDMASK: begin
                    if (wr_data[6])
                        spec_mask <= wr_data[5];
                    if (wr_data[1])
                        read_isr <= wr_data[0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_init_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int MODE_W = 5,
    localparam int PRIO_W = $clog2(NUM_LINES),
    localparam int VEC_W = BYTE_W - PRIO_W
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 port_sel,
    input  logic [BYTE_W-1:0]    wr_data,
    output logic [VEC_W-1:0]     vec_base,
    output logic [BYTE_W-1:0]    cascade_id,
    output logic [MODE_W-1:0]    mode_flags,
    output logic [NUM_LINES-1:0] irq_mask,
    output logic [PRIO_W-1:0]    lowest_prio,
    output logic                 spec_mask,
    output logic                 read_isr,
    output logic                 init_busy,
    output logic                 icw1_illegal
);
    wr_kind_e kind;
    step_e    step;

    pic_wr_decode u_dec (
        .wr_en    (wr_en),
        .port_sel (port_sel),
        .wr_data  (wr_data),
        .kind     (kind)
    );

    pic_init_step u_step (
        .clk  (clk),
        .rst  (rst),
        .kind (kind),
        .step (step),
        .busy (init_busy)
    );

    pic_cfg_regs #(.NUM_LINES(NUM_LINES), .MODE_W(MODE_W)) u_cfg (
        .clk          (clk),
        .rst          (rst),
        .kind         (kind),
        .step         (step),
        .wr_data      (wr_data),
        .vec_base     (vec_base),
        .cascade_id   (cascade_id),
        .mode_flags   (mode_flags),
        .irq_mask     (irq_mask),
        .lowest_prio  (lowest_prio),
        .spec_mask    (spec_mask),
        .read_isr     (read_isr),
        .icw1_illegal (icw1_illegal)
    );
endmodule

// File: rtl/pic_init_seq_chk.sv
module pic_init_seq_chk #(
    parameter int NUM_LINES = 8,
    localparam int PRIO_W = $clog2(NUM_LINES)
)(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic                 port_sel,
    input logic [7:0]           wr_data,
    input logic [7:0]           cascade_id,
    input logic [NUM_LINES-1:0] irq_mask,
    input logic [PRIO_W-1:0]    lowest_prio,
    input logic                 spec_mask,
    input logic                 read_isr,
    input logic                 init_busy,
    input logic                 icw1_illegal
);
    logic start_wr, data_wr;
    logic armed;
    logic [1:0] taken;

    assign start_wr = wr_en && !port_sel && wr_data[4];
    assign data_wr  = wr_en && port_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            taken <= '0;
        end else if (start_wr) begin
            armed <= 1'b1;
            taken <= '0;
        end else if (armed && data_wr) begin
            if (taken == 2'd2)
                armed <= 1'b0;
            taken <= taken + 2'd1;
        end
    end

    // R2 / R11: busy tracks an independent count of sequence words
    p_busy_track_r2: assert property (@(posedge clk) disable iff (rst)
        init_busy == armed);

    // R3: start word forces defaults
    p_start_defaults_r3: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> (irq_mask == '0) && (lowest_prio == PRIO_W'(NUM_LINES-1))
                     && (cascade_id == 8'd7) && !spec_mask && !read_isr && init_busy);

    // R4: third data word closes the sequence, mask held meanwhile
    p_third_word_ends_r4: assert property (@(posedge clk) disable iff (rst)
        armed && data_wr && taken == 2'd2 |=> !init_busy);

    p_mask_held_r4: assert property (@(posedge clk) disable iff (rst)
        init_busy && data_wr |=> $stable(irq_mask));

    // R6: illegal start word flagged
    p_illegal_flag_r6: assert property (@(posedge clk) disable iff (rst)
        start_wr && (!wr_data[0] || wr_data[1]) |=> icw1_illegal);

    // R8: idle data write loads mask
    p_idle_mask_r8: assert property (@(posedge clk) disable iff (rst)
        !init_busy && data_wr |=> irq_mask == $past(wr_data[NUM_LINES-1:0]));
endmodule

bind pic_init_seq pic_init_seq_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .port_sel     (port_sel),
    .wr_data      (wr_data),
    .cascade_id   (cascade_id),
    .irq_mask     (irq_mask),
    .lowest_prio  (lowest_prio),
    .spec_mask    (spec_mask),
    .read_isr     (read_isr),
    .init_busy    (init_busy),
    .icw1_illegal (icw1_illegal)
);

// File: tb/pic_init_seq_tb.sv
`timescale 1ns/1ps
module pic_init_seq_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic       port_sel;
    logic [7:0] wr_data;
    logic [4:0] vec_base;
    logic [7:0] cascade_id;
    logic [4:0] mode_flags;
    logic [7:0] irq_mask;
    logic [2:0] lowest_prio;
    logic       spec_mask, read_isr, init_busy, icw1_illegal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    int m_vec, m_casc, m_mode, m_mask, m_prio, m_sm, m_rs, m_ill;
    int m_left;   // sequence words still expected

    always #4 clk = ~clk;

    pic_init_seq u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .port_sel(port_sel), .wr_data(wr_data),
        .vec_base(vec_base), .cascade_id(cascade_id), .mode_flags(mode_flags),
        .irq_mask(irq_mask), .lowest_prio(lowest_prio), .spec_mask(spec_mask),
        .read_isr(read_isr), .init_busy(init_busy), .icw1_illegal(icw1_illegal)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "vec_base", int'(vec_base), m_vec);
        check(tag, "cascade_id", int'(cascade_id), m_casc);
        check(tag, "mode_flags", int'(mode_flags), m_mode);
        check(tag, "irq_mask", int'(irq_mask), m_mask);
        check(tag, "lowest_prio", int'(lowest_prio), m_prio);
        check(tag, "spec_mask", int'(spec_mask), m_sm);
        check(tag, "read_isr", int'(read_isr), m_rs);
        check(tag, "init_busy", int'(init_busy), (m_left > 0) ? 1 : 0);
        check(tag, "icw1_illegal", int'(icw1_illegal), m_ill);
    endtask

    function automatic void model_reset();
        m_vec = 0; m_casc = 7; m_mode = 0; m_mask = 0; m_prio = 7;
        m_sm = 0; m_rs = 0; m_ill = 0; m_left = 0;
    endfunction

    function automatic void model_write(input int port, input int d);
        if (port == 1) begin
            if (m_left == 3)      m_vec  = d / 8;
            else if (m_left == 2) m_casc = d;
            else if (m_left == 1) m_mode = d % 32;
            else                  m_mask = d;
            if (m_left > 0) m_left--;
        end else if ((d & 8'h10) != 0) begin
            m_mask = 0; m_prio = 7; m_casc = 7; m_sm = 0; m_rs = 0;
            m_ill = (((d & 1) == 0) || ((d & 2) != 0)) ? 1 : 0;
            m_left = 3;
        end else if ((d & 8'h08) != 0) begin
            if ((d & 8'h40) != 0) m_sm = (d >> 5) & 1;
            if ((d & 8'h02) != 0) m_rs = d & 1;
        end else if ((d >> 6) == 3) begin
            m_prio = d & 7;
        end
    endfunction

    task automatic wr(input string tag, input int port, input int d);
        wr_en = 1'b1; port_sel = port[0]; wr_data = d[7:0];
        @(posedge clk);
        model_write(port, d);
        @(negedge clk);
        wr_en = 1'b0;
        compare_all(tag);
    endtask

    task automatic idle(input string tag);
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit [7:0] lfsr;
        rst = 1'b1; wr_en = 1'b0; port_sel = 1'b0; wr_data = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all("R1");
        idle("R1");

        // full sequence
        wr("R2", 0, 8'h11);
        wr("R4", 1, 8'h40);
        wr("R4", 1, 8'h04);
        wr("R4", 1, 8'h1D);
        idle("R4");

        // idle mask load then start word clears it; bits 3:2 set
        wr("R8", 1, 8'hA5);
        wr("R8", 1, 8'h3C);
        wr("R9", 0, 8'h68);
        wr("R9", 0, 8'h0B);
        wr("R10", 0, 8'hC2);
        wr("R3", 0, 8'h1D);
        wr("R5", 1, 8'h78);
        wr("R5", 1, 8'h80);
        wr("R5", 1, 8'h0F);

        // illegal start words still take three words
        wr("R6", 0, 8'h10);
        wr("R6", 1, 8'h08);
        wr("R6", 1, 8'h01);
        wr("R6", 1, 8'h02);
        wr("R8", 1, 8'h5A);
        wr("R6", 0, 8'h13);
        wr("R6", 1, 8'hF8);

        // restart mid-sequence
        wr("R7", 0, 8'h11);
        wr("R7", 1, 8'h20);
        wr("R7", 0, 8'h15);
        wr("R7", 1, 8'h88);
        wr("R7", 1, 8'h02);
        wr("R7", 1, 8'h03);
        wr("R8", 1, 8'hFF);

        // read/mask word
        wr("R9", 0, 8'h68);
        wr("R9", 0, 8'h0B);
        wr("R9", 0, 8'h28);
        wr("R9", 0, 8'h09);
        wr("R9", 0, 8'h48);
        wr("R9", 0, 8'h0A);

        // priority word
        wr("R10", 0, 8'hC3);
        wr("R10", 0, 8'hE5);
        wr("R10", 0, 8'h20);
        wr("R10", 0, 8'h66);
        wr("R10", 0, 8'hA1);

        // operation words inside the sequence
        wr("R11", 0, 8'h11);
        wr("R11", 1, 8'hB0);
        wr("R11", 0, 8'hC1);
        wr("R11", 1, 8'h02);
        wr("R11", 0, 8'h68);
        wr("R11", 0, 8'h0B);
        wr("R11", 1, 8'h11);
        wr("R11", 1, 8'h77);
        idle("R11");

        // pseudo-random mix
        lfsr = 8'h5B;
        for (int i = 0; i < 400; i++) begin
            int port;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            port = (lfsr[2] ^ lfsr[6]) ? 1 : 0;
            if (i % 7 == 3) idle("R4");
            else wr("R11", port, int'(lfsr ^ 8'(i)));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule